// File: doc/BRIEF.md
# Buffer Address Generator with Swizzle

This block turns one vector buffer memory instruction into a byte address for every lane. A resource descriptor describes the buffer: a 48-bit base, a record stride, a record count, a swizzle switch, an element size, an index stride and a switch that adds each lane's thread number to its index. The instruction adds two enable bits that select the per-lane vector index and the per-lane vector offset, a 12-bit immediate offset, and a scalar offset that all lanes share.

Two layouts are supported. In the linear layout each record follows the previous one. In the swizzled layout, elements of consecutive indices are interleaved in groups of index-stride records. For each lane the block also does a range check against the record count. A lane that fails this check is reported in an out-of-range mask. The memory path then returns zero for that lane on a load and drops its write on a store. Lanes whose execute bit is clear are carried through as inactive.

Each result is registered once. Valid/ready handshakes on the input and on the output let a back-pressured consumer stall the producer without losing an instruction.

Top module: `buf_addr_gen`

## Requirements
- R1: The lane index is the lane's vector index when `inst_idx_en` is 1 (otherwise 0), plus the lane number (0 for the lowest lane) when `desc_tid_en` is 1 (otherwise 0).
- R2: The lane offset is the lane's vector offset when `inst_off_en` is 1 (otherwise 0), plus the zero-extended `inst_imm_off`.
- R3: When `desc_swz_en` is 0, the address is base + scalar offset + offset + stride × index, taken modulo 2^48.
- R4: When `desc_swz_en` is 1, let E be the element size (`desc_elem_sz` code 0,1,2,3 selects 2,4,8,16 bytes) and let S be the index stride (`desc_idx_stride` code 0,1,2,3 selects 8,16,32,64). The buffer offset is ((index/S × stride + (offset/E) × E) × S) + (index mod S) × E + offset mod E. The address is base + scalar offset + buffer offset, modulo 2^48.
- R5: When the stride is 0 or the layout is swizzled, an active lane is out of range when its buffer offset is at least `desc_num_rec`. In the linear layout the buffer offset is offset + stride × index.
- R6: When the stride is non-zero and the layout is linear, an active lane is out of range when its index is at least `desc_num_rec`. Each lane is judged on its own.
- R7: `out_active` holds the execute mask captured with the instruction. A lane whose execute bit is 0 never has its `out_oob` bit set.
- R8: An instruction accepted on a clock edge appears on the outputs after that edge. The outputs hold steady while `out_valid` is 1 and `out_ready` is 0. Results leave in the order the instructions were accepted.
- R9: After reset `out_valid` is 0. `in_ready` is 1 whenever the output register is empty or is being drained in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted when high together with in_valid |
| desc_base | input | 48 | Buffer base byte address |
| desc_stride | input | 14 | Record stride in bytes |
| desc_num_rec | input | 32 | Record count (bytes when the byte check applies) |
| desc_swz_en | input | 1 | 1 selects the swizzled layout |
| desc_elem_sz | input | 2 | Element size code: 2 << code bytes |
| desc_idx_stride | input | 2 | Index stride code: 8 << code records |
| desc_tid_en | input | 1 | Add lane number to index |
| inst_idx_en | input | 1 | Use vector index |
| inst_off_en | input | 1 | Use vector offset |
| inst_imm_off | input | 12 | Immediate byte offset |
| inst_soff | input | 32 | Scalar byte offset |
| lane_vidx | input | LANES×32 | Per-lane vector index, lane 0 in the low bits |
| lane_voff | input | LANES×32 | Per-lane vector offset, lane 0 in the low bits |
| lane_exec | input | LANES | Execute mask |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | LANES×48 | Per-lane byte address, lane 0 in the low bits |
| out_oob | output | LANES | Out-of-range lanes |
| out_active | output | LANES | Captured execute mask |

## Verification
The bench builds the block with its defaults: four lanes, 32-bit vector operands, a 14-bit stride and a 12-bit immediate. With four lanes the thread number can cross an index-stride boundary in the swizzled layout, and each of the four codes for element size and index stride is swept. A base just below 2^48 reaches the address wrap. A small record count puts the in-range and out-of-range boundaries in neighbouring lanes of the same instruction. A repeating stall pattern on `out_ready` exercises holding and back-to-back transfers.

// File: rtl/buf_addr_pkg.sv
package buf_addr_pkg;
  localparam int AW = 48;
  typedef logic [AW-1:0] addr_t;

  typedef enum logic [1:0] {ESZ_2, ESZ_4, ESZ_8, ESZ_16} esz_e;
  typedef enum logic [1:0] {IST_8, IST_16, IST_32, IST_64} ist_e;

  function automatic int unsigned esz_log2(esz_e c);
    return 32'd1 + 32'(c);
  endfunction

  function automatic int unsigned ist_log2(ist_e c);
    return 32'd3 + 32'(c);
  endfunction

  // record-after-record layout: offset inside the buffer
  function automatic addr_t lin_boff(addr_t idx, addr_t off, addr_t stride);
    return off + stride * idx;
  endfunction

  // interleaved layout; power-of-two sizes turn divide/modulo into shift/mask
  function automatic addr_t swz_boff(addr_t idx, addr_t off, addr_t stride,
                                     esz_e ec, ist_e ic);
    int unsigned el;
    int unsigned il;
    addr_t imsb, ilsb, omsb, olsb;
    el   = esz_log2(ec);
    il   = ist_log2(ic);
    imsb = idx >> il;
    ilsb = idx & ((addr_t'(1) << il) - addr_t'(1));
    omsb = off >> el;
    olsb = off & ((addr_t'(1) << el) - addr_t'(1));
    return (((imsb * stride) + (omsb << el)) << il) + (ilsb << el) + olsb;
  endfunction
endpackage

// File: rtl/buf_lane_addr.sv
module buf_lane_addr
  import buf_addr_pkg::*;
#(
  parameter int LANE_ID  = 0,
  parameter int DW       = 32,
  parameter int STRIDE_W = 14,
  parameter int REC_W    = 32,
  parameter int IMM_W    = 12
) (
  input  logic                exec,
  input  logic [DW-1:0]       vidx,
  input  logic [DW-1:0]       voff,
  input  logic                idx_en,
  input  logic                off_en,
  input  logic                tid_en,
  input  logic [IMM_W-1:0]    imm,
  input  logic [DW-1:0]       soff,
  input  addr_t               base,
  input  logic [STRIDE_W-1:0] stride,
  input  logic [REC_W-1:0]    nrec,
  input  logic                swz,
  input  esz_e                esz,
  input  ist_e                ist,
  output addr_t               addr,
  output logic                oob
);
  addr_t lane_index;
  addr_t lane_offset;
  addr_t lane_boff;
  addr_t stride_x;
  addr_t nrec_x;
  logic  byte_check;

  always_comb begin
    stride_x    = addr_t'(stride);
    nrec_x      = addr_t'(nrec);
    lane_index  = (idx_en ? addr_t'(vidx) : '0) + (tid_en ? addr_t'(LANE_ID) : '0);
    lane_offset = (off_en ? addr_t'(voff) : '0) + addr_t'(imm);
    lane_boff   = swz ? swz_boff(lane_index, lane_offset, stride_x, esz, ist)
                      : lin_boff(lane_index, lane_offset, stride_x);
    addr        = base + addr_t'(soff) + lane_boff;
    byte_check  = swz || (stride == '0);
    oob         = exec && (byte_check ? (lane_boff >= nrec_x) : (lane_index >= nrec_x));
  end
endmodule

// File: rtl/buf_out_stage.sv
module buf_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/buf_addr_gen.sv
module buf_addr_gen
  import buf_addr_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int DW       = 32,
  parameter int STRIDE_W = 14,
  parameter int REC_W    = 32,
  parameter int IMM_W    = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [AW-1:0]         desc_base,
  input  logic [STRIDE_W-1:0]   desc_stride,
  input  logic [REC_W-1:0]      desc_num_rec,
  input  logic                  desc_swz_en,
  input  logic [1:0]            desc_elem_sz,
  input  logic [1:0]            desc_idx_stride,
  input  logic                  desc_tid_en,
  input  logic                  inst_idx_en,
  input  logic                  inst_off_en,
  input  logic [IMM_W-1:0]      inst_imm_off,
  input  logic [DW-1:0]         inst_soff,
  input  logic [LANES*DW-1:0]   lane_vidx,
  input  logic [LANES*DW-1:0]   lane_voff,
  input  logic [LANES-1:0]      lane_exec,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [LANES*AW-1:0]   out_addr,
  output logic [LANES-1:0]      out_oob,
  output logic [LANES-1:0]      out_active
);
  localparam int ADDR_BUS = LANES * AW;
  localparam int PW       = ADDR_BUS + 2 * LANES;

  logic [ADDR_BUS-1:0] lane_addr;
  logic [LANES-1:0]    lane_oob;
  logic                accept;
  logic [PW-1:0]       stage_in;
  logic [PW-1:0]       stage_out;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    buf_lane_addr #(
      .LANE_ID(g), .DW(DW), .STRIDE_W(STRIDE_W), .REC_W(REC_W), .IMM_W(IMM_W)
    ) u_lane (
      .exec   (lane_exec[g]),
      .vidx   (lane_vidx[g*DW +: DW]),
      .voff   (lane_voff[g*DW +: DW]),
      .idx_en (inst_idx_en),
      .off_en (inst_off_en),
      .tid_en (desc_tid_en),
      .imm    (inst_imm_off),
      .soff   (inst_soff),
      .base   (desc_base),
      .stride (desc_stride),
      .nrec   (desc_num_rec),
      .swz    (desc_swz_en),
      .esz    (esz_e'(desc_elem_sz)),
      .ist    (ist_e'(desc_idx_stride)),
      .addr   (lane_addr[g*AW +: AW]),
      .oob    (lane_oob[g])
    );
  end

  assign accept   = in_valid && in_ready;
  assign stage_in = {lane_exec, lane_oob, lane_addr};

  buf_out_stage #(.W(PW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (stage_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (stage_out)
  );

  assign out_addr   = stage_out[ADDR_BUS-1:0];
  assign out_oob    = stage_out[ADDR_BUS +: LANES];
  assign out_active = stage_out[ADDR_BUS+LANES +: LANES];
endmodule

// File: rtl/buf_addr_gen_chk.sv
module buf_addr_gen_chk #(
  parameter int LANES = 4,
  parameter int AW    = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LANES-1:0] lane_exec,
  input logic [LANES-1:0] lane_oob,
  input logic             accept,
  input logic             out_valid,
  input logic             out_ready,
  input logic [LANES*AW-1:0] out_addr,
  input logic [LANES-1:0] out_oob,
  input logic [LANES-1:0] out_active
);
  // R7
  raw_oob_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oob & ~lane_exec) == '0);

  // R7
  out_oob_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_oob & ~out_active) == '0));

  // R7
  active_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_active == $past(lane_exec)));

  // R8
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_oob) && $stable(out_active)));

  // R8
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R9
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind buf_addr_gen buf_addr_gen_chk #(.LANES(LANES), .AW(buf_addr_pkg::AW)) u_chk (.*);

// File: tb/buf_addr_gen_tb.sv
module buf_addr_gen_tb;
  localparam int LANES = 4;
  localparam int DW    = 32;
  localparam int AW    = 48;
  localparam bit [63:0] MASK48 = 64'hFFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [AW-1:0] desc_base = '0;
  logic [13:0] desc_stride = '0;
  logic [31:0] desc_num_rec = '0;
  logic desc_swz_en = 1'b0;
  logic [1:0] desc_elem_sz = '0;
  logic [1:0] desc_idx_stride = '0;
  logic desc_tid_en = 1'b0;
  logic inst_idx_en = 1'b0;
  logic inst_off_en = 1'b0;
  logic [11:0] inst_imm_off = '0;
  logic [31:0] inst_soff = '0;
  logic [LANES*DW-1:0] lane_vidx = '0;
  logic [LANES*DW-1:0] lane_voff = '0;
  logic [LANES-1:0] lane_exec = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [LANES*AW-1:0] out_addr;
  logic [LANES-1:0] out_oob;
  logic [LANES-1:0] out_active;

  always #10 clk = ~clk;

  buf_addr_gen u_dut (.*);

  int compared = 0;
  int mismatched = 0;
  bit stall_mode = 1'b0;
  bit finished = 1'b0;
  int rdy_cnt = 0;
  string cur_tag = "";

  logic [LANES*AW-1:0] q_addr[$];
  logic [LANES-1:0]    q_oob[$];
  logic [LANES-1:0]    q_act[$];
  string               q_tag[$];

  function automatic void ref_lane(int l, output bit [47:0] a, output bit o);
    bit [63:0] idx, off, bo, st, es, is;
    idx = (inst_idx_en ? 64'(lane_vidx[l*DW +: DW]) : 64'd0) + (desc_tid_en ? 64'(l) : 64'd0);
    off = (inst_off_en ? 64'(lane_voff[l*DW +: DW]) : 64'd0) + 64'(inst_imm_off);
    st  = 64'(desc_stride);
    es  = 64'd2 << desc_elem_sz;
    is  = 64'd8 << desc_idx_stride;
    if (desc_swz_en) bo = ((idx / is) * st + (off / es) * es) * is + (idx % is) * es + (off % es);
    else             bo = off + st * idx;
    bo = bo & MASK48;
    a  = 48'((64'(desc_base) + 64'(inst_soff) + bo) & MASK48);
    if (!lane_exec[l]) o = 1'b0;
    else if (st == 0 || desc_swz_en) o = (bo >= 64'(desc_num_rec));
    else o = (idx >= 64'(desc_num_rec));
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // out_ready driver
  initial forever begin
    @(negedge clk); #2;
    out_ready = stall_mode ? ((rdy_cnt % 3) != 0) : 1'b1;
    rdy_cnt++;
  end

  // per-cycle monitor and reference model, sampled 2 ns before the rising edge
  initial forever begin
    @(negedge clk); #8;
    if (rst_n) begin
      chk(out_valid == (q_addr.size() > 0), "R8", "out_valid", 64'(out_valid), 64'(q_addr.size() > 0));
      chk(in_ready == ((q_addr.size() == 0) || out_ready), "R9", "in_ready", 64'(in_ready),
          64'((q_addr.size() == 0) || out_ready));
      if (out_valid && q_addr.size() > 0) begin
        for (int l = 0; l < LANES; l++) begin
          if (q_act[0][l])
            chk(out_addr[l*AW +: AW] == q_addr[0][l*AW +: AW], q_tag[0], "addr",
                64'(out_addr[l*AW +: AW]), 64'(q_addr[0][l*AW +: AW]));
        end
        chk(out_oob == q_oob[0], q_tag[0], "oob", 64'(out_oob), 64'(q_oob[0]));
        chk(out_active == q_act[0], "R7", "active", 64'(out_active), 64'(q_act[0]));
        if (out_ready) begin
          void'(q_addr.pop_front()); void'(q_oob.pop_front());
          void'(q_act.pop_front());  void'(q_tag.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        logic [LANES*AW-1:0] ea;
        logic [LANES-1:0] eo;
        for (int l = 0; l < LANES; l++) begin
          bit [47:0] a;
          bit o;
          ref_lane(l, a, o);
          ea[l*AW +: AW] = a;
          eo[l] = o;
        end
        q_addr.push_back(ea); q_oob.push_back(eo);
        q_act.push_back(lane_exec); q_tag.push_back(cur_tag);
      end
    end
  end

  // entered at negedge+2; leaves at negedge+2 after acceptance
  task automatic send(string tag);
    bit acc;
    cur_tag = tag;
    in_valid = 1'b1;
    while (1) begin
      #6;
      acc = in_ready;
      @(negedge clk); #2;
      if (acc) break;
    end
  endtask

  task automatic idle();
    in_valid = 1'b0;
  endtask

  task automatic set_lanes(logic [31:0] i0, logic [31:0] i1, logic [31:0] i2, logic [31:0] i3,
                           logic [31:0] o0, logic [31:0] o1, logic [31:0] o2, logic [31:0] o3);
    lane_vidx = {i3, i2, i1, i0};
    lane_voff = {o3, o2, o1, o0};
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R9", "reset out_valid", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R9", "reset in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(out_valid == 1'b0, "R9", "post-reset out_valid", 64'(out_valid), 64'd0);

    // R1: index composition
    desc_base = 48'h1000; desc_stride = 14'd16; desc_num_rec = 32'd1000;
    lane_exec = 4'hF; inst_soff = 32'h40;
    set_lanes(5, 6, 7, 8, 0, 0, 0, 0);
    inst_idx_en = 1; desc_tid_en = 1; send("R1");
    desc_tid_en = 0; send("R1");
    inst_idx_en = 0; desc_tid_en = 1; send("R1");
    idle();

    // R2: offset composition
    desc_stride = 14'd4; desc_num_rec = 32'hFFFF_FFFF; inst_idx_en = 1; desc_tid_en = 0;
    set_lanes(1, 2, 3, 4, 3, 100, 32'hFFFF_FFFF, 7);
    inst_off_en = 1; inst_imm_off = 12'hFFF; inst_soff = 32'h20; send("R2");
    inst_off_en = 0; inst_imm_off = 12'h00C; send("R2");
    idle();

    // R3: linear with 48-bit wrap
    desc_base = 48'hFFFF_FFFF_FF00; inst_soff = 32'h200; desc_stride = 14'h3FFF;
    inst_off_en = 1; set_lanes(32'h0, 32'h10, 32'hFFFF, 32'h7FFF_FFFF, 9, 0, 16, 32'h8000_0000);
    send("R3");
    desc_base = 48'h0000_1234_5678; inst_soff = 32'hFFFF_FFFF; send("R3");
    idle();

    // R4: swizzled, all element-size and index-stride codes
    desc_swz_en = 1; desc_stride = 14'd64; desc_num_rec = 32'hFFFF_FFFF; desc_base = 48'h8000;
    inst_soff = 32'h10; inst_idx_en = 1; inst_off_en = 1; desc_tid_en = 1; inst_imm_off = 12'd3;
    set_lanes(0, 7, 9, 70, 0, 5, 33, 130);
    for (int e = 0; e < 4; e++) begin
      for (int s = 0; s < 4; s++) begin
        desc_elem_sz = 2'(e); desc_idx_stride = 2'(s);
        send("R4");
      end
    end
    idle();

    // R5: byte-granular range check, stride zero then swizzled
    desc_swz_en = 0; desc_stride = 14'd0; desc_num_rec = 32'd100; desc_tid_en = 0;
    inst_imm_off = 12'd0; set_lanes(0, 0, 0, 0, 99, 100, 101, 0);
    send("R5");
    desc_swz_en = 1; desc_elem_sz = 2'd1; desc_idx_stride = 2'd0; desc_stride = 14'd16;
    desc_num_rec = 32'd40; set_lanes(0, 1, 2, 9, 0, 0, 4, 0);
    send("R5");
    idle();

    // R6: index-based range check per lane
    desc_swz_en = 0; desc_stride = 14'd8; desc_num_rec = 32'd10; inst_off_en = 0;
    set_lanes(8, 9, 10, 11, 0, 0, 0, 0);
    send("R6");
    desc_tid_en = 1; set_lanes(9, 9, 9, 9, 0, 0, 0, 0); send("R6");
    idle();

    // R7: masked lanes never flagged
    desc_tid_en = 0; lane_exec = 4'b0101; set_lanes(11, 12, 3, 40, 0, 0, 0, 0); send("R7");
    lane_exec = 4'b0000; send("R7");
    lane_exec = 4'b1000; send("R7");
    idle();

    // R8: back-pressure with back-to-back instructions
    stall_mode = 1; lane_exec = 4'hF; desc_num_rec = 32'd50;
    for (int k = 0; k < 8; k++) begin
      desc_swz_en = k[0]; desc_elem_sz = 2'(k); desc_idx_stride = 2'(k >> 1);
      desc_stride = 14'(k * 12); inst_off_en = 1; desc_tid_en = k[1];
      set_lanes(32'(k), 32'(k * 3), 32'(k + 20), 32'(k * 7), 32'(k * 5), 32'(k + 1), 32'(k * 9), 32'(60 - k));
      send("R8");
    end
    idle();
    repeat (6) @(negedge clk);
    stall_mode = 0;
    while (q_addr.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finished = 1;
    summary();
  end
endmodule